// File: doc/BRIEF.md
# Per-Pin Configurable Port Output Stage

This block controls the output stage of one general-purpose port of a parameterised number of pins (eight by default). Every pin has its own drive type: quasi-bidirectional, open-drain, push-pull or off (high impedance). The type comes from two configuration registers, and each register supplies one bit per pin. A port data latch holds the value that is driven out. From the type and the latch value the block derives three pad-control enables per pin: a strong pull-down, a strong pull-up and a weak pull-up. It also returns the pin input level through a synchronizer. The input is readable in every drive type.

Software writes the registers over a small bus that has a write strobe, a two-bit register select and a data word. Each register is written on its own, so a pin that moves between types passes through one intermediate type for as long as the gap between the two writes lasts. A boot-mode strap is sampled while reset is held. With the strap low, every pin comes out of reset quasi-bidirectional. With the strap high, the pins that carry the external data bus come out push-pull instead.

Top module: `pcfg_port`

## Requirements
- R1: The drive type of pin n is set by the code {cfg_b[n], cfg_a[n]}: 2'b00 off, 2'b01 quasi-bidirectional, 2'b10 open-drain, 2'b11 push-pull. Each pin is decoded on its own, so any mix of types across the port is allowed.
- R2: After a reset with the strap low, every pin is quasi-bidirectional and the data latch holds all ones. On every pin only the weak pull-up is on, with no strong pull-up pulse.
- R3: After a reset with the strap high, the pins set in DBUS_MASK (default 8'h0F) are push-pull and the remaining pins are quasi-bidirectional. With the latch at all ones, the data-bus pins have the strong pull-up on and the rest have the weak pull-up on.
- R4: A write is taken at the rising clock edge while wr_en is high. wr_sel 0 selects the data latch, 1 selects cfg_a and 2 selects cfg_b. The pad enables show the new value right after that edge.
- R5: In quasi-bidirectional type, a latch bit of 0 turns on only the pull-down, and a latch bit of 1 turns on the weak pull-up. When the latch bit goes from 0 to 1, the strong pull-up is on for exactly the first clock cycle after the write.
- R6: In open-drain type, a latch bit of 0 turns on only the pull-down. A latch bit of 1 turns on no driver.
- R7: In push-pull type, a latch bit of 0 turns on the pull-down and a latch bit of 1 turns on the strong pull-up, held for as long as the bit stays 1. The weak pull-up stays off.
- R8: In off type, all three enables are low whatever the latch value.
- R9: pin_rd equals pin_in as it was SYNC_STAGES clock edges earlier (default 2), in every drive type.
- R10: Writing cfg_a and cfg_b on consecutive cycles produces the intermediate type for one cycle and then the final type.
- R11: No pin ever has its pull-down enabled together with either pull-up.
- R12: A write with wr_sel 3 changes no register and leaves every pad enable as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_romless | input | 1 | Boot strap, sampled on each clock while reset is held |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 latch, 1 cfg_a, 2 cfg_b, 3 none |
| wr_data | input | NPINS | Write data, one bit per pin |
| pin_in | input | NPINS | Pad input levels |
| pin_rd | output | NPINS | Synchronized pad input levels |
| pd_en | output | NPINS | Strong pull-down enables |
| pu_strong_en | output | NPINS | Strong pull-up enables |
| pu_weak_en | output | NPINS | Weak pull-up enables |

## Verification
The drive decode is tried with uniform ports in each of the four types, using latch patterns that mix ones and zeros. These patterns show whether the pull-down and pull-up paths track the latch with the correct polarity for each type. Two mixed patterns then place all four types on neighbouring pins, once with the high nibble of the latch set and once with the low nibble set. A swapped code bit or a shared decode between pins shows up in these as a wrong enable on a single pin. Directed sequences cover the quasi-bidirectional one-cycle strong pull-up, an intermediate type between back-to-back configuration writes, a write with the unused select, both strap values at reset, and the read-path latency.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

   typedef enum logic [1:0] {
      PM_OFF        = 2'd0,
      PM_QUASI      = 2'd1,
      PM_OPEN_DRAIN = 2'd2,
      PM_PUSH_PULL  = 2'd3
   } pin_mode_e;

   typedef enum logic [1:0] {
      SEL_LATCH = 2'd0,
      SEL_CFG_A = 2'd1,
      SEL_CFG_B = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // map holds four 2-bit fields; field c gives the mode for code c = {B,A}
   function automatic pin_mode_e mode_of(logic [7:0] map, logic [1:0] code);
      logic [1:0] f;
      f = map[2*code +: 2];
      return pin_mode_e'(f);
   endfunction

   function automatic logic [1:0] code_of(logic [7:0] map, pin_mode_e m);
      logic [1:0] r;
      r = 2'd0;
      for (int c = 0; c < 4; c++) begin
         if (map[2*c +: 2] == m) r = 2'(c);
      end
      return r;
   endfunction

   function automatic bit map_ok(logic [7:0] map);
      int hits;
      bit ok;
      ok = 1'b1;
      for (int m = 0; m < 4; m++) begin
         hits = 0;
         for (int c = 0; c < 4; c++) begin
            if (map[2*c +: 2] == 2'(m)) hits++;
         end
         if (hits != 1) ok = 1'b0;
      end
      return ok;
   endfunction

endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs #(
   parameter int          NPINS     = 8,
   parameter logic [NPINS-1:0] DBUS_MASK = 'h0F,
   parameter logic [7:0]  MODE_MAP  = 8'b11_10_01_00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_romless,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [NPINS-1:0] wr_data,
   output logic [NPINS-1:0] cfg_a,
   output logic [NPINS-1:0] cfg_b,
   output logic [NPINS-1:0] latch,
   output logic [NPINS-1:0] latch_prev
);
   import pcfg_pkg::*;

   localparam logic [1:0] QCODE = code_of(MODE_MAP, PM_QUASI);
   localparam logic [1:0] PCODE = code_of(MODE_MAP, PM_PUSH_PULL);

   logic [NPINS-1:0] rst_a;
   logic [NPINS-1:0] rst_b;

   // strap-dependent reset code for every pin
   always_comb begin
      for (int i = 0; i < NPINS; i++) begin
         if (boot_romless && DBUS_MASK[i]) begin
            rst_a[i] = PCODE[0];
            rst_b[i] = PCODE[1];
         end else begin
            rst_a[i] = QCODE[0];
            rst_b[i] = QCODE[1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_a <= rst_a;
         cfg_b <= rst_b;
         latch <= '1;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            SEL_LATCH: latch <= wr_data;
            SEL_CFG_A: cfg_a <= wr_data;
            SEL_CFG_B: cfg_b <= wr_data;
            default:   ;
         endcase
      end
   end

   // one-cycle history of the latch for the quasi pull-up pulse
   always_ff @(posedge clk) begin
      if (!rst_n) latch_prev <= '1;
      else        latch_prev <= latch;
   end

endmodule

// File: rtl/pcfg_pin_drv.sv
module pcfg_pin_drv #(
   parameter logic [7:0] MODE_MAP = 8'b11_10_01_00
) (
   input  logic [1:0] code,
   input  logic       lat,
   input  logic       lat_prev,
   output logic       pd,
   output logic       pu_strong,
   output logic       pu_weak
);
   import pcfg_pkg::*;

   pin_mode_e mode;
   logic      rise;

   assign mode = mode_of(MODE_MAP, code);
   assign rise = lat & ~lat_prev;

   always_comb begin
      pd        = 1'b0;
      pu_strong = 1'b0;
      pu_weak   = 1'b0;
      unique case (mode)
         PM_OFF: ;
         PM_QUASI: begin
            pd        = ~lat;
            pu_weak   = lat;
            pu_strong = rise;
         end
         PM_OPEN_DRAIN: begin
            pd = ~lat;
         end
         PM_PUSH_PULL: begin
            pd        = ~lat;
            pu_strong = lat;
         end
      endcase
   end

endmodule

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] din,
   output logic [NPINS-1:0] dout
);
   generate
      if (SYNC_STAGES == 1) begin : g_single
         logic [NPINS-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         localparam int W = SYNC_STAGES * NPINS;
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= {q[W-NPINS-1:0], din};
         end
         assign dout = q[W-1 -: NPINS];
      end
   endgenerate

endmodule

// File: rtl/pcfg_port.sv
module pcfg_port #(
   parameter int               NPINS       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [NPINS-1:0] DBUS_MASK   = 'h0F,
   parameter logic [7:0]       MODE_MAP    = 8'b11_10_01_00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_romless,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [NPINS-1:0] wr_data,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_rd,
   output logic [NPINS-1:0] pd_en,
   output logic [NPINS-1:0] pu_strong_en,
   output logic [NPINS-1:0] pu_weak_en
);
   import pcfg_pkg::*;

   generate
      if (NPINS < 1) begin : g_bad_npins
         $error("pcfg_port: NPINS must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pcfg_port: SYNC_STAGES must be at least 1");
      end
      if (!map_ok(MODE_MAP)) begin : g_bad_map
         $error("pcfg_port: MODE_MAP must name each mode exactly once");
      end
   endgenerate

   logic [NPINS-1:0] cfg_a;
   logic [NPINS-1:0] cfg_b;
   logic [NPINS-1:0] latch;
   logic [NPINS-1:0] latch_prev;

   pcfg_regs #(
      .NPINS     (NPINS),
      .DBUS_MASK (DBUS_MASK),
      .MODE_MAP  (MODE_MAP)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .boot_romless (boot_romless),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .cfg_a        (cfg_a),
      .cfg_b        (cfg_b),
      .latch        (latch),
      .latch_prev   (latch_prev)
   );

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         pcfg_pin_drv #(
            .MODE_MAP (MODE_MAP)
         ) u_drv (
            .code      ({cfg_b[i], cfg_a[i]}),
            .lat       (latch[i]),
            .lat_prev  (latch_prev[i]),
            .pd        (pd_en[i]),
            .pu_strong (pu_strong_en[i]),
            .pu_weak   (pu_weak_en[i])
         );
      end
   endgenerate

   pcfg_sync #(
      .NPINS       (NPINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (pin_rd)
   );

endmodule

// File: rtl/pcfg_port_chk.sv
module pcfg_port_chk #(
   parameter int         NPINS    = 8,
   parameter logic [7:0] MODE_MAP = 8'b11_10_01_00
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [NPINS-1:0] cfg_a,
   input logic [NPINS-1:0] cfg_b,
   input logic [NPINS-1:0] latch,
   input logic [NPINS-1:0] pd_en,
   input logic [NPINS-1:0] pu_strong_en,
   input logic [NPINS-1:0] pu_weak_en
);
   import pcfg_pkg::*;

   // R12: unused select leaves every register alone
   a_r12_sel_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(latch)));

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pin_mode_e m;
      assign m = mode_of(MODE_MAP, {cfg_b[i], cfg_a[i]});

      // R11
      a_r11_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
         !(pd_en[i] && (pu_strong_en[i] || pu_weak_en[i])));

      // R8
      a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (m == PM_OFF) |-> (!pd_en[i] && !pu_strong_en[i] && !pu_weak_en[i]));

      // R6
      a_r6_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
         (m == PM_OPEN_DRAIN) |-> (!pu_strong_en[i] && !pu_weak_en[i] && (pd_en[i] == !latch[i])));

      // R7
      a_r7_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
         (m == PM_PUSH_PULL) |-> (!pu_weak_en[i] && (pd_en[i] == !latch[i]) && (pu_strong_en[i] == latch[i])));

      // R5: low latch in quasi type pulls down only
      a_r5_quasi_low: assert property (@(posedge clk) disable iff (!rst_n)
         (m == PM_QUASI && !latch[i]) |-> (pd_en[i] && !pu_strong_en[i] && !pu_weak_en[i]));

      // R5: strong pull-up in quasi type never lasts two cycles
      a_r5_quasi_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
         (m == PM_QUASI && pu_strong_en[i]) |=> (m != PM_QUASI || !pu_strong_en[i]));
   end

endmodule

bind pcfg_port pcfg_port_chk #(
   .NPINS    (NPINS),
   .MODE_MAP (MODE_MAP)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .cfg_a        (cfg_a),
   .cfg_b        (cfg_b),
   .latch        (latch),
   .pd_en        (pd_en),
   .pu_strong_en (pu_strong_en),
   .pu_weak_en   (pu_weak_en)
);

// File: tb/sim_pcfg_port.sv
`timescale 1ns/1ps
module sim_pcfg_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boot_romless = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_rd;
   logic [7:0] pd_en;
   logic [7:0] pu_strong_en;
   logic [7:0] pu_weak_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   pcfg_port u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .boot_romless (boot_romless),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .pin_in       (pin_in),
      .pin_rd       (pin_rd),
      .pd_en        (pd_en),
      .pu_strong_en (pu_strong_en),
      .pu_weak_en   (pu_weak_en)
   );

   // {cfg_b, cfg_a, latch, exp pd, exp strong pu, exp weak pu}
   localparam logic [47:0] VEC [0:5] = '{
      48'h00FF_F00F_00F0,
      48'hFFFF_A55A_A500,
      48'hFF00_3CC3_0000,
      48'h0000_0000_0000,
      48'hCCAA_F00E_8020,
      48'hCCAA_0FE0_0802
   };

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk3(string req, logic [7:0] pd, logic [7:0] pus, logic [7:0] puw);
      chk(req, "pd_en", pd_en, pd);
      chk(req, "pu_strong_en", pu_strong_en, pus);
      chk(req, "pu_weak_en", pu_weak_en, puw);
   endtask

   // called at a falling edge; returns at the next falling edge with the write taken
   task automatic put(logic [1:0] sel, logic [7:0] d);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = d;
      @(negedge clk);
   endtask

   task automatic idle();
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset(logic strap);
      boot_romless = strap;
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      boot_romless = 1'b0;
   endtask

   task automatic wrap_up();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         wrap_up();
      end
   end

   initial begin
      @(negedge clk);
      // R2: reset default, strap low
      do_reset(1'b0);
      chk3("R2", 8'h00, 8'h00, 8'hFF);
      chk("R9", "pin_rd after reset", pin_rd, 8'h00);

      // R1 R5 R6 R7 R8 R11: table walk
      for (int k = 0; k < 6; k++) begin
         put(2'd2, VEC[k][47:40]);
         put(2'd1, VEC[k][39:32]);
         put(2'd0, VEC[k][31:24]);
         idle();
         idle();
         chk3("R1", VEC[k][23:16], VEC[k][15:8], VEC[k][7:0]);
         chk("R11", "fight mask", pd_en & (pu_strong_en | pu_weak_en), 8'h00);
      end

      // R12: unused select after the last vector
      put(2'd3, 8'h55);
      idle();
      chk3("R12", 8'hE0, 8'h08, 8'h02);

      // R5 / R4: quasi strong pull-up pulse
      put(2'd2, 8'h00);
      put(2'd1, 8'hFF);
      put(2'd0, 8'h00);
      idle();
      chk3("R5", 8'hFF, 8'h00, 8'h00);
      put(2'd0, 8'hFF);
      chk3("R4", 8'h00, 8'hFF, 8'hFF);
      idle();
      chk3("R5", 8'h00, 8'h00, 8'hFF);
      idle();
      chk("R5", "pu_strong_en later", pu_strong_en, 8'h00);

      // R10: off -> quasi (intermediate) -> push-pull, back to back
      put(2'd1, 8'h00);
      idle();
      chk3("R8", 8'h00, 8'h00, 8'h00);
      put(2'd1, 8'hFF);
      chk3("R10", 8'h00, 8'h00, 8'hFF);
      put(2'd2, 8'hFF);
      chk3("R10", 8'h00, 8'hFF, 8'h00);
      idle();
      chk3("R10", 8'h00, 8'hFF, 8'h00);

      // R9: read path in push-pull and in off type
      pin_in = 8'h5A;
      idle();
      chk("R9", "pin_rd after one edge", pin_rd, 8'h00);
      idle();
      chk("R9", "pin_rd after two edges", pin_rd, 8'h5A);
      put(2'd2, 8'h00);
      put(2'd1, 8'h00);
      pin_in = 8'hC3;
      idle();
      idle();
      chk("R9", "pin_rd in off type", pin_rd, 8'hC3);

      // R3: strap high selects push-pull on data-bus pins
      do_reset(1'b1);
      chk3("R3", 8'h00, 8'h0F, 8'hF0);

      done = 1'b1;
      wrap_up();
   end

endmodule